// File: doc/BRIEF.md
# Interrupt Controller Programming Interface

This block is the register front end of an eight-line prioritised interrupt controller. Software reaches it through two byte addresses. A write strobe with an address bit and a data byte carries three things: a multi-word configuration sequence, mode commands, and priority/end-of-interrupt commands. A read strobe returns the pending vector, the in-service vector, the mask, or the result of a one-shot poll. The pending and in-service vectors live in a neighbouring block. They come in as inputs, and this block asks for bits to be cleared through one-cycle clear-request vectors.

The block holds the mask, the vector base, the nesting and automatic-EOI flags, the rotate-on-automatic-EOI flag, the special-mask flag, the register-select bit, the poll flag and the rotation base (the line that currently ranks highest). It keeps its own rotated priority search. That search serves non-specific end-of-interrupt and poll reads. Acknowledge cycles and cascading are left to other blocks. Line rotation is modulo the line count, which is a power of two.

Top module: `intc_prog_if`

## Requirements
- R1: After reset the mask, vector base, rotation base and every mode flag are 0, configuration is not busy, no clear request is raised, and a read of address 0 returns the pending vector.
- R2: A write to address 0 with data bit 4 set starts configuration. It clears the mask, vector base, rotation base, poll, register-select, special-mask, nesting and automatic-EOI state, and raises clear requests for all eight pending and all eight in-service bits in that cycle. It sets busy and stores data bit 0 as the "fourth word wanted" flag.
- R3: The first address-1 write after the start word sets the vector base to the data with its low three bits forced to 0.
- R4: The second address-1 write ends configuration unless a fourth word was wanted. The fourth word sets nesting from bit 4 and automatic EOI from bit 1, then ends configuration.
- R5: Outside configuration, an address-1 write loads the mask, and a non-poll read of address 1 returns it.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. Bit 1 allows register-select to take bit 0. Bit 6 allows special-mask to take bit 5. A flag whose enable bit is 0 keeps its value.
- R7: With bits 4 and 3 both clear, bits 7:5 form the command code. Codes 0 and 4 set rotate-on-automatic-EOI to data bit 7.
- R8: Code 1 requests clearing the in-service line that ranks highest. Ranking starts at the rotation base and goes upward modulo 8. Code 5 does the same and also sets the rotation base to that line + 1. Neither has an effect when nothing is in service.
- R9: Code 3 requests clearing in-service line data[2:0]. Code 7 does the same and sets the rotation base to data[2:0] + 1 modulo 8.
- R10: Code 6 sets the rotation base to data[2:0] + 1 modulo 8.
- R11: Code 2 changes nothing and raises no clear request, and no clear request is ever raised without a strobe.
- R12: A read while poll is armed, at either address, returns the winning line. The winner is the highest-ranked unmasked pending line, provided it ranks above every in-service line. The read also requests clearing that line's pending and in-service bits. With no winner it returns 7 and requests nothing. The read disarms poll.
- R13: A non-poll read of address 0 returns the in-service vector when register-select is 1 and the pending vector when it is 0.
- R14: While configuration is busy, address-1 writes do not change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| pend_i | input | 8 | Pending vector from the request block |
| insvc_i | input | 8 | In-service vector from the service block |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| mask_o | output | 8 | Interrupt mask |
| vbase_o | output | 8 | Vector base, low three bits 0 |
| prio_base_o | output | 3 | Line that currently ranks highest |
| nested_o | output | 1 | Fully nested mode flag |
| aeoi_o | output | 1 | Automatic EOI flag |
| rot_aeoi_o | output | 1 | Rotate-on-automatic-EOI flag |
| smask_o | output | 1 | Special mask flag |
| cfg_busy_o | output | 1 | Configuration sequence in progress |
| irr_clr_o | output | 8 | Pending-bit clear requests, same cycle as the strobe |
| isr_clr_o | output | 8 | In-service clear requests, same cycle as the strobe |

## Verification
The bench drives the rotation base near 7 so that both non-specific EOI and poll have to wrap past line 7. A design that searched from line 0 would clear or return the wrong line. It runs a poll in which the best pending line ties with an in-service line. A design that used "not lower" in place of "strictly higher" would report that line instead of 7. It also checks that poll disarms after one read, so a sticky poll shows up when the following read returns a line number in place of the pending vector. It runs configuration both with and without the fourth word. This catches a sequencer that miscounts or writes the mask during configuration, and mode-command writes whose enable bit is 0, which must leave the flag alone.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int unsigned NLINES = 8;               // interrupt lines, power of two
  localparam int unsigned LW     = $clog2(NLINES);  // line index width
  localparam int unsigned DW     = 8;               // bus data width

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_MODE} init_step_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR   = 3'd0, OP_EOI_NS    = 3'd1, OP_NOP       = 3'd2,
    OP_EOI_SP    = 3'd3, OP_ROT_SET   = 3'd4, OP_EOI_NS_RB = 3'd5,
    OP_SET_BASE  = 3'd6, OP_EOI_SP_RB = 3'd7
  } op_e;

  // Rank (0 = best) of the best set bit, counting upward from base; NLINES if empty.
  function automatic logic [LW:0] first_rank(input logic [NLINES-1:0] req,
                                             input logic [LW-1:0] base);
    logic [LW:0]   r;
    logic [LW-1:0] idx;
    r = (LW+1)'(NLINES);
    for (int k = NLINES - 1; k >= 0; k--) begin
      idx = base + k[LW-1:0];
      if (req[idx]) r = k[LW:0];
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] rank_to_line(input logic [LW:0] rank,
                                                 input logic [LW-1:0] base);
    return base + rank[LW-1:0];
  endfunction

  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] line);
    return line + 1'b1;
  endfunction
endpackage

// File: rtl/intc_cmd_dec.sv
`timescale 1ns/1ps
module intc_cmd_dec
  import intc_pkg::*;
(
  input  logic       wr_i,
  input  logic       addr_i,
  input  logic [4:0] ctl_i,      // write data bits 7:3
  output logic       init_o,
  output logic       mode_o,
  output logic       op_vld_o,
  output op_e        op_o,
  output logic       data_wr_o
);
  logic ctl_wr;
  assign ctl_wr    = wr_i && !addr_i;
  assign init_o    = ctl_wr && ctl_i[1];
  assign mode_o    = ctl_wr && !ctl_i[1] && ctl_i[0];
  assign op_vld_o  = ctl_wr && !ctl_i[1] && !ctl_i[0];
  assign op_o      = op_e'(ctl_i[4:2]);
  assign data_wr_o = wr_i && addr_i;
endmodule

// File: rtl/intc_init_fsm.sv
`timescale 1ns/1ps
module intc_init_fsm
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       need4_i,
  input  logic       data_wr_i,
  output init_step_e step_o
);
  init_step_e step_q;
  logic       need4_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= ST_RUN;
      need4_q <= 1'b0;
    end else if (start_i) begin
      step_q  <= ST_BASE;
      need4_q <= need4_i;
    end else if (data_wr_i) begin
      case (step_q)
        ST_BASE: step_q <= ST_CASC;
        ST_CASC: step_q <= need4_q ? ST_MODE : ST_RUN;
        ST_MODE: step_q <= ST_RUN;
        default: step_q <= ST_RUN;
      endcase
    end
  end

  assign step_o = step_q;

  p_step_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && data_wr_i && step_q == ST_CASC && !need4_q) |=> step_q == ST_RUN);
endmodule

// File: rtl/intc_resolve.sv
`timescale 1ns/1ps
module intc_resolve
  import intc_pkg::*;
(
  input  logic [NLINES-1:0] pend_i,
  input  logic [NLINES-1:0] mask_i,
  input  logic [NLINES-1:0] insvc_i,
  input  logic [LW-1:0]     base_i,
  output logic              win_vld_o,
  output logic [LW-1:0]     win_line_o,
  output logic              top_vld_o,
  output logic [LW-1:0]     top_line_o
);
  logic [LW:0] req_rank, svc_rank;

  assign req_rank   = first_rank(pend_i & ~mask_i, base_i);
  assign svc_rank   = first_rank(insvc_i, base_i);
  assign win_vld_o  = req_rank < svc_rank;   // strictly outranks all in service
  assign win_line_o = rank_to_line(req_rank, base_i);
  assign top_vld_o  = svc_rank != (LW+1)'(NLINES);
  assign top_line_o = rank_to_line(svc_rank, base_i);
endmodule

// File: rtl/intc_prog_if.sv
`timescale 1ns/1ps
module intc_prog_if
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [NLINES-1:0] pend_i,
  input  logic [NLINES-1:0] insvc_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NLINES-1:0] mask_o,
  output logic [DW-1:0]     vbase_o,
  output logic [LW-1:0]     prio_base_o,
  output logic              nested_o,
  output logic              aeoi_o,
  output logic              rot_aeoi_o,
  output logic              smask_o,
  output logic              cfg_busy_o,
  output logic [NLINES-1:0] irr_clr_o,
  output logic [NLINES-1:0] isr_clr_o
);
  localparam logic [DW-1:0] BASE_KEEP = {DW{1'b1}} << LW;

  // named internal events
  logic       init_w, mode_w, op_w, data_wr, poll_rd;
  op_e        op;
  init_step_e step;
  logic       win_vld, top_vld;
  logic [LW-1:0] win_line, top_line, wline;

  logic [NLINES-1:0] mask_q;
  logic [DW-1:0]     vbase_q;
  logic [LW-1:0]     pbase_q;
  logic nested_q, aeoi_q, rot_aeoi_q, smask_q, rsel_q, poll_q;

  intc_cmd_dec u_dec (
    .wr_i(wr_i), .addr_i(addr_i), .ctl_i(wdata_i[7:3]),
    .init_o(init_w), .mode_o(mode_w), .op_vld_o(op_w), .op_o(op), .data_wr_o(data_wr)
  );

  intc_init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(init_w), .need4_i(wdata_i[0]),
    .data_wr_i(data_wr), .step_o(step)
  );

  intc_resolve u_res (
    .pend_i(pend_i), .mask_i(mask_q), .insvc_i(insvc_i), .base_i(pbase_q),
    .win_vld_o(win_vld), .win_line_o(win_line), .top_vld_o(top_vld), .top_line_o(top_line)
  );

  assign poll_rd    = rd_i && poll_q;
  assign wline      = wdata_i[LW-1:0];
  assign cfg_busy_o = step != ST_RUN;

  always_ff @(posedge clk) begin
    if (!rst_n || init_w) begin
      mask_q <= '0; vbase_q <= '0; pbase_q <= '0;
      nested_q <= 1'b0; aeoi_q <= 1'b0; rot_aeoi_q <= 1'b0;
      smask_q <= 1'b0; rsel_q <= 1'b0; poll_q <= 1'b0;
    end else begin
      if (poll_rd) poll_q <= 1'b0;
      if (mode_w) begin
        if (wdata_i[2]) poll_q  <= 1'b1;
        if (wdata_i[1]) rsel_q  <= wdata_i[0];
        if (wdata_i[6]) smask_q <= wdata_i[5];
      end
      if (op_w) begin
        case (op)
          OP_ROT_CLR, OP_ROT_SET:    rot_aeoi_q <= wdata_i[7];
          OP_EOI_NS_RB:              if (top_vld) pbase_q <= next_line(top_line);
          OP_SET_BASE, OP_EOI_SP_RB: pbase_q <= next_line(wline);
          default: ;
        endcase
      end
      if (data_wr) begin
        case (step)
          ST_RUN:  mask_q  <= wdata_i[NLINES-1:0];
          ST_BASE: vbase_q <= wdata_i & BASE_KEEP;
          ST_MODE: begin nested_q <= wdata_i[4]; aeoi_q <= wdata_i[1]; end
          default: ;
        endcase
      end
    end
  end

  // clear requests, valid in the strobe cycle
  always_comb begin
    irr_clr_o = '0;
    isr_clr_o = '0;
    if (init_w) begin
      irr_clr_o = '1;
      isr_clr_o = '1;
    end else if (op_w && (op == OP_EOI_NS || op == OP_EOI_NS_RB)) begin
      if (top_vld) isr_clr_o[top_line] = 1'b1;
    end else if (op_w && (op == OP_EOI_SP || op == OP_EOI_SP_RB)) begin
      isr_clr_o[wline] = 1'b1;
    end else if (poll_rd && win_vld) begin
      irr_clr_o[win_line] = 1'b1;
      isr_clr_o[win_line] = 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (poll_q)      rdata_o[LW-1:0]     = win_vld ? win_line : LW'(NLINES - 1);
    else if (addr_i) rdata_o[NLINES-1:0] = mask_q;
    else             rdata_o[NLINES-1:0] = rsel_q ? insvc_i : pend_i;
  end

  assign mask_o      = mask_q;
  assign vbase_o     = vbase_q;
  assign prio_base_o = pbase_q;
  assign nested_o    = nested_q;
  assign aeoi_o      = aeoi_q;
  assign rot_aeoi_o  = rot_aeoi_q;
  assign smask_o     = smask_q;

  // ---------------- assertions ----------------
  p_init_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_w |=> (mask_o == '0 && prio_base_o == '0 && cfg_busy_o && !nested_o && !smask_o));
  p_mask_guard_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cfg_busy_o) |=> $stable(mask_o));
  p_poll_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !mode_w) |=> !poll_q);
  p_poll_hit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && irr_clr_o != '0) |-> (irr_clr_o[rdata_o[LW-1:0]] && pend_i[rdata_o[LW-1:0]]));
  p_single_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_w |-> $onehot0(isr_clr_o));
  p_ns_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w && (op == OP_EOI_NS || op == OP_EOI_NS_RB)) |-> ((isr_clr_o & ~insvc_i) == '0));
  p_set_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_w && op == OP_SET_BASE) |=> prio_base_o == next_line($past(wdata_i[LW-1:0])));
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !rd_i) |-> (irr_clr_o == '0 && isr_clr_o == '0));
endmodule

// File: tb/test_intc_prog_if.sv
`timescale 1ns/1ps
module test_intc_prog_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] pend = '0, insvc = '0;
  logic [7:0] rdata, mask, vbase, irr_clr, isr_clr;
  logic [2:0] pbase;
  logic       nested, aeoi, rot_aeoi, smask, busy;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  intc_prog_if i_intc_prog_if (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .pend_i(pend), .insvc_i(insvc), .rdata_o(rdata), .mask_o(mask), .vbase_o(vbase),
    .prio_base_o(pbase), .nested_o(nested), .aeoi_o(aeoi), .rot_aeoi_o(rot_aeoi),
    .smask_o(smask), .cfg_busy_o(busy), .irr_clr_o(irr_clr), .isr_clr_o(isr_clr)
  );

  typedef struct packed {
    logic       a;   logic [7:0] d;   logic w;   logic r;
    logic [7:0] p;   logic [7:0] s;
    logic [7:0] erd; logic [7:0] eisc; logic [7:0] eirc;
    logic [2:0] epb; logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h0F, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd5 },  // R5 mask load
    '{1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h00, 3'd0, 4'd5 },  // R5 mask read
    '{1'b0, 8'h0B, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd6 },  // R6 select in-service
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h33, 8'h84, 8'h84, 8'h00, 8'h00, 3'd0, 4'd13},  // R13
    '{1'b0, 8'h0A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd6 },  // R6 select pending
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h33, 8'h84, 8'h33, 8'h00, 8'h00, 3'd0, 4'd13},  // R13
    '{1'b0, 8'hC4, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd5, 4'd10},  // R10 base 5
    '{1'b0, 8'h20, 1'b1, 1'b0, 8'h00, 8'h84, 8'h00, 8'h80, 8'h00, 3'd5, 4'd8 },  // R8 wraps to 7
    '{1'b0, 8'hA0, 1'b1, 1'b0, 8'h00, 8'h05, 8'h00, 8'h01, 8'h00, 3'd1, 4'd8 },  // R8 rotating
    '{1'b0, 8'h20, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1, 4'd8 },  // R8 empty
    '{1'b0, 8'h66, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 3'd1, 4'd9 },  // R9 specific 6
    '{1'b0, 8'hE3, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 3'd4, 4'd9 },  // R9 specific+rotate
    '{1'b0, 8'hE7, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 3'd0, 4'd9 },  // R9 wrap
    '{1'b0, 8'hC2, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd3, 4'd10},  // R10
    '{1'b0, 8'h45, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd3, 4'd11},  // R11 code 2
    '{1'b0, 8'hC7, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd10},  // R10 wrap
    '{1'b0, 8'h0C, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd6 },  // R6 arm poll
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'hF2, 8'h00, 8'h04, 8'h10, 8'h10, 3'd0, 4'd12},  // R12 masked lines skipped
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'hF2, 8'h00, 8'hF2, 8'h00, 8'h00, 3'd0, 4'd12},  // R12 disarmed
    '{1'b0, 8'h0C, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd6 },
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h30, 8'h10, 8'h07, 8'h00, 8'h00, 3'd0, 4'd12},  // R12 tie -> none
    '{1'b0, 8'h0C, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 4'd6 },
    '{1'b1, 8'h00, 1'b0, 1'b1, 8'h20, 8'h40, 8'h05, 8'h20, 8'h20, 3'd0, 4'd12},  // R12 at address 1
    '{1'b0, 8'hC5, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd6, 4'd10},  // R10 base 6
    '{1'b0, 8'h0C, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd6, 4'd6 },
    '{1'b0, 8'h00, 1'b0, 1'b1, 8'h90, 8'h00, 8'h07, 8'h80, 8'h80, 3'd6, 4'd12}   // R12 rotated winner 7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample the combinational outputs 5 ns later
  task automatic drive(input logic a, input logic [7:0] d, input logic w, input logic r,
                       input logic [7:0] p, input logic [7:0] s);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r; pend = p; insvc = s;
    #5;
  endtask

  // let the rising edge pass, drop strobes, settle
  task automatic release_strobes;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    #1;
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    drive(a, d, 1'b1, 1'b0, pend, insvc);
    release_strobes();
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pend = 8'h5A;
    #2;
    // R1 reset state
    chk("R1 mask", mask, 8'h00);
    chk("R1 vbase", vbase, 8'h00);
    chk("R1 prio base", pbase, 3'd0);
    chk("R1 flags", {nested, aeoi, rot_aeoi, smask, busy}, 5'b0);
    chk("R1 clears", {irr_clr, isr_clr}, 16'h0);
    chk("R1 read pending", rdata, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].a, TBL[i].d, TBL[i].w, TBL[i].r, TBL[i].p, TBL[i].s);
      if (TBL[i].r) chk($sformatf("R%0d vec %0d rdata", TBL[i].req, i), rdata, TBL[i].erd);
      chk($sformatf("R%0d vec %0d isr_clr", TBL[i].req, i), isr_clr, TBL[i].eisc);
      chk($sformatf("R%0d vec %0d irr_clr", TBL[i].req, i), irr_clr, TBL[i].eirc);
      release_strobes();
      chk($sformatf("R%0d vec %0d prio base", TBL[i].req, i), pbase, TBL[i].epb);
    end

    // R7 rotate-on-automatic-EOI flag
    wr_reg(1'b0, 8'h80);
    chk("R7 code 4 sets", rot_aeoi, 1'b1);
    wr_reg(1'b0, 8'h00);
    chk("R7 code 0 clears", rot_aeoi, 1'b0);

    // R6 special mask, enable bit gating
    wr_reg(1'b0, 8'h68);
    chk("R6 special mask set", smask, 1'b1);
    wr_reg(1'b0, 8'h28);
    chk("R6 special mask held without enable", smask, 1'b1);

    // R2 start word with fourth word wanted
    wr_reg(1'b0, 8'h0C);   // arm poll before start
    drive(1'b0, 8'h11, 1'b1, 1'b0, 8'h3C, 8'hC3);
    chk("R2 pending clear all", irr_clr, 8'hFF);
    chk("R2 in-service clear all", isr_clr, 8'hFF);
    release_strobes();
    chk("R2 mask cleared", mask, 8'h00);
    chk("R2 base cleared", pbase, 3'd0);
    chk("R2 special mask cleared", smask, 1'b0);
    chk("R2 busy", busy, 1'b1);
    drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h3C, 8'hC3);
    chk("R2 poll cleared, pending read", rdata, 8'h3C);
    release_strobes();

    wr_reg(1'b1, 8'h4D);
    chk("R3 vector base", vbase, 8'h48);
    chk("R14 mask untouched step 1", mask, 8'h00);
    wr_reg(1'b1, 8'h55);
    chk("R4 still busy for fourth word", busy, 1'b1);
    chk("R14 mask untouched step 2", mask, 8'h00);
    wr_reg(1'b1, 8'h12);
    chk("R4 nested and auto EOI", {nested, aeoi}, 2'b11);
    chk("R4 done", busy, 1'b0);
    chk("R14 mask untouched step 3", mask, 8'h00);
    wr_reg(1'b1, 8'h3C);
    chk("R5 mask after configuration", mask, 8'h3C);

    // R4 short sequence without the fourth word
    wr_reg(1'b0, 8'h10);
    chk("R2 flags cleared", {nested, aeoi}, 2'b00);
    wr_reg(1'b1, 8'h27);
    chk("R3 low bits dropped", vbase, 8'h20);
    wr_reg(1'b1, 8'h00);
    chk("R4 three-word sequence done", busy, 1'b0);
    wr_reg(1'b1, 8'hAA);
    chk("R5 mask in normal state", mask, 8'hAA);
    chk("R4 nested stays clear", nested, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule